// File: doc/BRIEF.md
# Rotating Priority Interrupt Resolver

This block is a single eight-line interrupt request stage with its priority resolver. Each clock edge samples the raw request lines into a pending register. Each line has its own trigger kind. A level line copies its input. An edge line latches a rising edge and holds it until the surrounding command logic clears it. The pending bits that are not masked are candidates. A scan picks the highest-priority candidate and compares it with the highest-priority line currently in service. An interrupt is raised only when the candidate outranks that line.

Priority is rotating. A 3-bit base offset chooses which line is most urgent. The scan then walks the lines upward from that offset, wrapping past line 7. One nested option is meant for an instance at the root of a cascade. When it is enabled, the in-service bit of the cascade line does not count in the comparison, so a further request can arrive through that line while it is being serviced. Command decoding, acknowledge sequencing and cascading between instances belong to the surrounding logic. That logic drives the mask, in-service, rotation and clear inputs.

Top module: `irq_rotor`

## Requirements
- R1: For a line with `level_sel` bit 1, the `pending` bit equals the level of `req_in` sampled at the previous clock edge. It sets on high and clears on low.
- R2: For a line with `level_sel` bit 0, the `pending` bit sets after an edge at which `req_in` is high and the level sampled at the edge before was low. Once set, it stays set while the input stays high or goes low.
- R3: A `req_clr` bit clears the matching edge-line `pending` bit at the next edge. If a rising edge on that line is sampled at the same edge, the bit stays set. `req_clr` has no effect on level lines.
- R4: A line whose `mask_bits` bit is 1 is never reported. Candidates are `pending & ~mask_bits`.
- R5: Lines are ranked in the order `(k + rot_base) mod 8` for k = 0..7, where a smaller k means more urgent. The reported `irq_line` is the most urgent candidate line.
- R6: `irq_valid` is 1 only when the most urgent candidate is strictly more urgent than the most urgent set bit of `svc_bits`, both ranked with the same rotation. An equal or less urgent candidate gives 0. An empty `svc_bits` ranks below all lines.
- R7: When `nest_excl` is 1 and the instance is a cascade root (parameter `NEST_MASTER`), bit `CASCADE_LINE` (default 2) of `svc_bits` is ignored in the R6 comparison.
- R8: When `irq_valid` is 0, `irq_line` is 0. Reset clears all pending and edge-history state, so after reset `irq_valid` is 0.
- R9: `irq_valid` and `irq_line` follow changes of `mask_bits`, `svc_bits`, `rot_base` and `nest_excl` in the same cycle, with no register on the way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_in | input | 8 | Raw interrupt request lines |
| level_sel | input | 8 | Per-line trigger kind: 1 level, 0 edge |
| req_clr | input | 8 | Per-line clear of a latched edge request |
| mask_bits | input | 8 | Per-line mask, 1 blocks the line |
| svc_bits | input | 8 | Lines currently in service |
| rot_base | input | 3 | Most urgent line of the rotating order |
| nest_excl | input | 1 | Ignore the cascade line's in-service bit |
| pending | output | 8 | Captured request register |
| irq_valid | output | 1 | An interrupt should be raised |
| irq_line | output | 3 | Winning line number, 0 when not valid |

## Verification
An edge line can receive a clear and a new rising edge at the same clock edge. The bench provokes this by driving a line high from a low history while its `req_clr` bit is asserted. It then judges the outcome from `pending` at the next sample: the bit must remain set. The bench also changes the mask, in-service and rotation inputs between edges and checks the outputs in the same cycle. A pseudo-random sweep compares every result with a rank-based model built in the bench.

// File: rtl/irq_rotor_pkg.sv
package irq_rotor_pkg;
  localparam int unsigned LINES = 8;                 // power of two: ranks wrap by truncation
  localparam int unsigned IDX_W = $clog2(LINES);

  typedef logic [IDX_W-1:0] line_t;
  typedef logic [IDX_W:0]   prio_t;                  // one extra bit for the empty sentinel

  localparam prio_t PRIO_NONE = prio_t'(LINES);

  // line reached k steps after the rotation base
  function automatic line_t wrap_add(line_t a, line_t b);
    return line_t'(a + b);
  endfunction
endpackage

// File: rtl/irq_capture.sv
module irq_capture
  import irq_rotor_pkg::*;
#(
  parameter int unsigned N = LINES
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] line_i,
  input  logic [N-1:0] level_sel_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] req_o
);
  for (genvar g = 0; g < N; g++) begin : g_line
    logic hist_q;
    logic req_q;
    logic rise_w;

    assign rise_w = line_i[g] & ~hist_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hist_q <= 1'b0;
        req_q  <= 1'b0;
      end else begin
        hist_q <= line_i[g];
        if (level_sel_i[g])  req_q <= line_i[g];
        else if (rise_w)     req_q <= 1'b1;
        else if (clr_i[g])   req_q <= 1'b0;
      end
    end

    assign req_o[g] = req_q;

    // R1: level line copies the sampled input
    a_r1_level_copy: assert property (@(posedge clk) disable iff (!rst_n)
      level_sel_i[g] |=> (req_q == $past(line_i[g])));
    // R2: a sampled rising edge latches the request
    a_r2_edge_set: assert property (@(posedge clk) disable iff (!rst_n)
      (!level_sel_i[g] && line_i[g] && !hist_q) |=> req_q);
    // R2: a low input does not drop a latched edge request
    a_r2_edge_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!level_sel_i[g] && !line_i[g] && req_q && !clr_i[g]) |=> req_q);
    // R3: clear without a fresh edge drops the request
    a_r3_edge_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (!level_sel_i[g] && clr_i[g] && !(line_i[g] && !hist_q)) |=> !req_q);
  end
endmodule

// File: rtl/irq_prio_scan.sv
module irq_prio_scan
  import irq_rotor_pkg::*;
(
  input  logic [LINES-1:0] set_i,
  input  line_t            rot_i,
  output prio_t            rank_o
);
  // walk from the least urgent step down so the most urgent hit is kept
  always_comb begin
    rank_o = PRIO_NONE;
    for (int k = LINES - 1; k >= 0; k--) begin
      if (set_i[wrap_add(line_t'(k), rot_i)]) rank_o = prio_t'(k);
    end
  end
endmodule

// File: rtl/irq_rotor.sv
module irq_rotor
  import irq_rotor_pkg::*;
#(
  parameter int unsigned CASCADE_LINE = 2,
  parameter bit          NEST_MASTER  = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] req_in,
  input  logic [LINES-1:0] level_sel,
  input  logic [LINES-1:0] req_clr,
  input  logic [LINES-1:0] mask_bits,
  input  logic [LINES-1:0] svc_bits,
  input  logic [IDX_W-1:0] rot_base,
  input  logic             nest_excl,
  output logic [LINES-1:0] pending,
  output logic             irq_valid,
  output logic [IDX_W-1:0] irq_line
);
  logic [LINES-1:0] cand_w;
  logic [LINES-1:0] svc_eff_w;
  prio_t            cand_rank_w;
  prio_t            svc_rank_w;
  logic             win_w;

  irq_capture #(.N(LINES)) u_capture (
    .clk         (clk),
    .rst_n       (rst_n),
    .line_i      (req_in),
    .level_sel_i (level_sel),
    .clr_i       (req_clr),
    .req_o       (pending)
  );

  assign cand_w = pending & ~mask_bits;

  if (NEST_MASTER) begin : g_nest
    logic [LINES-1:0] excl_w;
    assign excl_w    = nest_excl ? (LINES'(1) << CASCADE_LINE) : '0;
    assign svc_eff_w = svc_bits & ~excl_w;
  end else begin : g_flat
    assign svc_eff_w = svc_bits;
  end

  irq_prio_scan u_cand_scan (.set_i(cand_w),    .rot_i(rot_base), .rank_o(cand_rank_w));
  irq_prio_scan u_svc_scan  (.set_i(svc_eff_w), .rot_i(rot_base), .rank_o(svc_rank_w));

  assign win_w     = cand_rank_w < svc_rank_w;
  assign irq_valid = win_w;
  assign irq_line  = win_w ? wrap_add(cand_rank_w[IDX_W-1:0], rot_base) : '0;

  // R4: the reported line is an unmasked pending line
  a_r4_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (pending[irq_line] && !mask_bits[irq_line]));
  // R6: the reported line is never one that already blocks it
  a_r6_not_in_service: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> !svc_eff_w[irq_line]);
  // R7: only the cascade line in service cannot block a candidate
  a_r7_cascade_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (NEST_MASTER && nest_excl && (svc_bits == (LINES'(1) << CASCADE_LINE)) && (cand_w != '0))
      |-> irq_valid);
  // R8: no candidates means no interrupt, and an idle line number is zero
  a_r8_empty_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (cand_w == '0) |-> !irq_valid);
  a_r8_line_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_valid |-> (irq_line == '0));
endmodule

// File: tb/irq_rotor_tb_top.sv
`timescale 1ns/1ps
module irq_rotor_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] req_in = '0, level_sel = 8'hFF, req_clr = '0, mask_bits = '0, svc_bits = '0;
  logic [2:0] rot_base = '0;
  logic       nest_excl = 1'b0;
  logic [7:0] pending;
  logic       irq_valid;
  logic [2:0] irq_line;
  int         checks = 0, errors = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  irq_rotor dut_i (
    .clk(clk), .rst_n(rst_n), .req_in(req_in), .level_sel(level_sel), .req_clr(req_clr),
    .mask_bits(mask_bits), .svc_bits(svc_bits), .rot_base(rot_base), .nest_excl(nest_excl),
    .pending(pending), .irq_valid(irq_valid), .irq_line(irq_line)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // model: rank of a line is its distance above the rotation base
  function automatic logic [3:0] ref_pick(input logic [7:0] cand, input logic [7:0] svc,
                                          input logic [2:0] rot, input bit excl);
    int best_c = 8, best_s = 8;
    logic [2:0] win = '0;
    logic [7:0] s = excl ? (svc & 8'hFB) : svc;
    for (int l = 0; l < 8; l++) begin
      logic [2:0] rk = 3'(l) - rot;
      if (cand[l] && int'(rk) < best_c) begin best_c = int'(rk); win = 3'(l); end
      if (s[l] && int'(rk) < best_s) best_s = int'(rk);
    end
    return (best_c < best_s) ? {1'b1, win} : 4'b0000;
  endfunction

  task automatic chk_out(input string tag);
    logic [3:0] e = ref_pick(pending & ~mask_bits, svc_bits, rot_base, nest_excl);
    chk(tag, {28'b0, irq_valid, irq_line}, {28'b0, e});
  endtask

  task automatic load_pending(input logic [7:0] pat);
    level_sel = 8'hFF;
    req_in    = pat;
    step();
  endtask

  task automatic t_reset();
    chk("R8 reset pending", pending, 8'h00);
    chk("R8 reset valid/line", {irq_valid, irq_line}, 4'b0000);
  endtask

  task automatic t_level();
    load_pending(8'h28);
    chk("R1 level set", pending, 8'h28);
    chk("R5 level winner", {irq_valid, irq_line}, {1'b1, 3'd3});
    req_in = 8'h00;
    step();
    chk("R1 level clear", pending, 8'h00);
    chk("R8 idle line zero", {irq_valid, irq_line}, 4'b0000);
  endtask

  task automatic t_edge();
    level_sel = 8'h00; req_in = 8'h00; step();
    req_in = 8'h10; step();
    chk("R2 edge latch", pending, 8'h10);
    step();
    chk("R2 held while high", pending, 8'h10);
    req_in = 8'h00; step();
    chk("R2 held after low", pending, 8'h10);
    req_clr = 8'h10; step(); req_clr = 8'h00;
    chk("R3 clear drops", pending, 8'h00);
    req_in = 8'h10; step();
    req_clr = 8'h10; step(); req_clr = 8'h00;
    chk("R3 clear while high, no new edge", pending, 8'h00);
    req_in = 8'h00; step();
  endtask

  task automatic t_collide();
    req_in = 8'h02; req_clr = 8'h02; step();
    chk("R3 edge beats clear", pending, 8'h02);
    req_clr = 8'h00; req_in = 8'h00; step();
    req_clr = 8'h02; step(); req_clr = 8'h00;
    chk("R3 clear after collision", pending, 8'h00);
    level_sel = 8'h01; req_in = 8'h01; step();
    req_clr = 8'h01; step(); req_clr = 8'h00;
    chk("R3 clear ignored on level line", pending, 8'h01);
    req_in = 8'h00; level_sel = 8'hFF; step();
  endtask

  task automatic t_mask();
    load_pending(8'h0A);
    chk("R5 lowest line wins", {irq_valid, irq_line}, {1'b1, 3'd1});
    mask_bits = 8'h02; #1;
    chk("R4 R9 masked winner skipped", {irq_valid, irq_line}, {1'b1, 3'd3});
    mask_bits = 8'h0A; #1;
    chk("R4 all masked", {irq_valid, irq_line}, 4'b0000);
    mask_bits = 8'h00; #1;
  endtask

  task automatic t_rotate();
    load_pending(8'h81);
    rot_base = 3'd1; #1;
    chk("R5 R9 rot1 picks 7", {irq_valid, irq_line}, {1'b1, 3'd7});
    rot_base = 3'd7; #1;
    chk("R5 rot7 picks 7", {irq_valid, irq_line}, {1'b1, 3'd7});
    rot_base = 3'd0; #1;
    chk("R5 rot0 picks 0", {irq_valid, irq_line}, {1'b1, 3'd0});
  endtask

  task automatic t_svc();
    load_pending(8'h20);
    svc_bits = 8'h08; #1;
    chk("R6 higher in service blocks", irq_valid, 1'b0);
    svc_bits = 8'h20; #1;
    chk("R6 equal in service blocks", irq_valid, 1'b0);
    svc_bits = 8'h40; #1;
    chk("R6 lower in service passes", {irq_valid, irq_line}, {1'b1, 3'd5});
    svc_bits = 8'h08; rot_base = 3'd4; #1;
    chk("R6 rotation reorders service", {irq_valid, irq_line}, {1'b1, 3'd5});
    svc_bits = 8'h00; rot_base = 3'd0; #1;
  endtask

  task automatic t_nest();
    load_pending(8'h10);
    svc_bits = 8'h04; nest_excl = 1'b0; #1;
    chk("R7 cascade counts when off", irq_valid, 1'b0);
    nest_excl = 1'b1; #1;
    chk("R7 cascade ignored", {irq_valid, irq_line}, {1'b1, 3'd4});
    svc_bits = 8'h06; #1;
    chk("R7 other service still blocks", irq_valid, 1'b0);
    svc_bits = 8'h00; nest_excl = 1'b0; #1;
  endtask

  task automatic t_sweep();
    logic [31:0] lf = 32'hACE1_2357;
    for (int i = 0; i < 60; i++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      load_pending(lf[7:0]);
      mask_bits = lf[15:8] & lf[23:16];
      svc_bits  = lf[23:16] & lf[31:24];
      rot_base  = lf[26:24];
      nest_excl = lf[29];
      #1;
      chk_out("R5 R6 R4 R7 sweep");
    end
    mask_bits = '0; svc_bits = '0; rot_base = '0; nest_excl = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_level();
    t_edge();
    t_collide();
    t_mask();
    t_rotate();
    t_svc();
    t_nest();
    t_sweep();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule